// File: doc/BRIEF.md
# Quad DAC Code Register Bank with Double Buffering

This block stores the digital codes for a four-channel digital-to-analog converter. Each channel has a staging register and an output register. A serial front end, outside this block, collects a 12-bit command word. It then presents that word here together with a one-cycle execute strobe. The bank decodes the word and does one of the following: it stages a code, stages and outputs a code, writes one code to every output register, moves every staged code to its output register, or does nothing. The output registers drive the converter codes. A registered flag tells the front end which clock edge its serial data output should use.

Two pins act outside the command path. An active-low clear empties every staging and output register at once. It does not wait for a clock, and it overrides everything else. An active-low load level makes the output registers follow the staging registers, so a staged code reaches the output in the same clock cycle. The power-on reset clears the registers and selects rising-edge output timing. The clear pin leaves the edge flag alone.

Top module: `qdac_regbank`

## Requirements
- R1: A word with control field bits [9:8] = 01 writes data bits [7:0] into the staging register selected by bits [11:10], where 0 selects channel A. While the load pin is high, no output code changes.
- R2: A word with control field 11 writes the data into both the staging register and the output register of the addressed channel. The output code changes on the clock edge that samples the strobe.
- R3: A word with control field 10 copies every staging register into its own output register. The address and data bits are ignored.
- R4: A word with control field 00 and address 01 writes the data byte into all four output registers. The staging registers are not changed.
- R5: A word with control field 00 and address 00 changes no register and leaves the edge flag unchanged.
- R6: Control 00 with address 10 sets the edge flag to 1, which selects falling-edge output. Control 00 with address 11 sets it to 0, which selects rising-edge output. Both of these commands also copy every staging register into its output register.
- R7: While the load pin is low, a staged code appears in its output register on the same clock edge that writes it.
- R8: Driving the clear pin low sets every staging and output code to 00h without waiting for a clock. The edge flag is not affected.
- R9: While the power-on reset is asserted, all output codes are 00h and the edge flag is 0.
- R10: While the clear pin is low, a command presented with the strobe has no effect on the codes. The load pin has no effect either.
- R11: A word presented with the strobe low is not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low. Asserts asynchronously and is released on a clock edge |
| clr_n | input | 1 | Clear of all codes, active low and asynchronous |
| ldac_n | input | 1 | Load level, active low. Output registers follow the staging registers while it is low |
| cmd_valid | input | 1 | Execute strobe for cmd_word, one cycle per command |
| cmd_word | input | 12 | Command: [11:10] address, [9:8] control, [7:0] data |
| dac_codes | output | 32 | Output codes, channel n in bits [8n+7:8n] |
| dout_on_fall | output | 1 | Edge flag: 1 selects falling-edge serial output, 0 selects rising-edge |

## Verification
The properties assume that cmd_valid, cmd_word and ldac_n change in step with clk. They also assume that no command is counted on while either reset synchronizer is still releasing. For that reason each command property is gated by the released state of both synchronizers. The bench drives every synchronous input on the falling clock edge. After releasing rst_n or clr_n it waits three cycles before the next command. It changes clr_n on a falling edge, so the asynchronous clear can be observed between clock edges.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_LOAD_IN,
    OP_LOAD_BOTH,
    OP_XFER,
    OP_BCAST,
    OP_MODE_FALL,
    OP_MODE_RISE
  } op_e;

  // control field codes (bits just above the data byte)
  localparam logic [1:0] CT_GLOBAL    = 2'b00;
  localparam logic [1:0] CT_LOAD_IN   = 2'b01;
  localparam logic [1:0] CT_XFER      = 2'b10;
  localparam logic [1:0] CT_LOAD_BOTH = 2'b11;

  // global sub-codes carried in the address field
  localparam logic [1:0] GA_NOP   = 2'b00;
  localparam logic [1:0] GA_BCAST = 2'b01;
  localparam logic [1:0] GA_FALL  = 2'b10;
  localparam logic [1:0] GA_RISE  = 2'b11;

endpackage

// File: rtl/qdac_rst_sync.sv
module qdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int AW = $clog2(NCH),
  localparam int CW = AW + 2 + DW
) (
  input  logic           cmd_valid,
  input  logic [CW-1:0]  cmd_word,
  output op_e            op,
  output logic [NCH-1:0] sel,
  output logic [DW-1:0]  data
);
  logic [AW-1:0] addr;
  logic [1:0]    ctrl;
  logic [1:0]    gcode;

  assign addr  = cmd_word[CW-1 -: AW];
  assign ctrl  = cmd_word[DW+1:DW];
  assign data  = cmd_word[DW-1:0];
  assign gcode = addr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = (addr == AW'(i));
  end

  always_comb begin
    op = OP_NOP;
    if (cmd_valid) begin
      unique case (ctrl)
        CT_LOAD_IN:   op = OP_LOAD_IN;
        CT_LOAD_BOTH: op = OP_LOAD_BOTH;
        CT_XFER:      op = OP_XFER;
        default: begin
          unique case (gcode)
            GA_BCAST: op = OP_BCAST;
            GA_FALL:  op = OP_MODE_FALL;
            GA_RISE:  op = OP_MODE_RISE;
            default:  op = OP_NOP;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_in,
  input  logic          ld_out,
  input  logic          bcast,
  input  logic          xfer,
  input  logic          transp,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] out_q
);
  logic [DW-1:0] stg_q;
  logic [DW-1:0] stg_d;
  logic [DW-1:0] out_d;
  logic          stg_en;
  logic          out_en;

  always_comb begin
    stg_en = ld_in;
    stg_d  = ld_in ? data : stg_q;
    out_en = bcast | ld_out | xfer | transp;
    if (bcast || ld_out) begin
      out_d = data;
    end else begin
      out_d = stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      out_q <= '0;
    end else begin
      if (stg_en) stg_q <= stg_d;
      if (out_en) out_q <= out_d;
    end
  end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int AW = $clog2(NCH),
  localparam int CW = AW + 2 + DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              ldac_n,
  input  logic              cmd_valid,
  input  logic [CW-1:0]     cmd_word,
  output logic [NCH*DW-1:0] dac_codes,
  output logic              dout_on_fall
);
  logic           por_rel_n;
  logic           clr_rel_n;
  logic           clr_src_n;
  op_e            op;
  logic [NCH-1:0] sel;
  logic [DW-1:0]  data;
  logic           xfer_all;
  logic           mode_en;
  logic           mode_d;

  assign clr_src_n = rst_n & clr_n;

  qdac_rst_sync #(.STAGES(2)) u_por_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(por_rel_n)
  );

  qdac_rst_sync #(.STAGES(2)) u_clr_sync (
    .clk(clk), .arst_n(clr_src_n), .srst_n(clr_rel_n)
  );

  qdac_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .op(op), .sel(sel), .data(data)
  );

  assign xfer_all = (op == OP_XFER) || (op == OP_MODE_FALL) || (op == OP_MODE_RISE);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qdac_chan #(.DW(DW)) u_ch (
      .clk(clk),
      .rst_n(clr_rel_n),
      .ld_in(sel[i] && (op == OP_LOAD_IN || op == OP_LOAD_BOTH)),
      .ld_out(sel[i] && (op == OP_LOAD_BOTH)),
      .bcast(op == OP_BCAST),
      .xfer(xfer_all),
      .transp(!ldac_n),
      .data(data),
      .out_q(dac_codes[i*DW +: DW])
    );
  end

  always_comb begin
    mode_en = (op == OP_MODE_FALL) || (op == OP_MODE_RISE);
    mode_d  = (op == OP_MODE_FALL);
  end

  always_ff @(posedge clk or negedge por_rel_n) begin
    if (!por_rel_n) begin
      dout_on_fall <= 1'b0;
    end else if (mode_en) begin
      dout_on_fall <= mode_d;
    end
  end
endmodule

// File: rtl/qdac_regbank_chk.sv
module qdac_regbank_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int AW = $clog2(NCH),
  localparam int CW = AW + 2 + DW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              ldac_n,
  input logic              cmd_valid,
  input logic [CW-1:0]     cmd_word,
  input logic [NCH*DW-1:0] dac_codes,
  input logic              dout_on_fall,
  input logic              por_rel_n,
  input logic              clr_rel_n
);
  logic          live;
  logic [AW-1:0] c_addr;
  logic [1:0]    c_ctrl;
  logic [DW-1:0] c_data;

  assign live   = por_rel_n && clr_rel_n && cmd_valid;
  assign c_addr = cmd_word[CW-1 -: AW];
  assign c_ctrl = cmd_word[DW+1:DW];
  assign c_data = cmd_word[DW-1:0];

  function automatic logic [DW-1:0] pick(logic [NCH*DW-1:0] v, logic [AW-1:0] idx);
    return v[idx*DW +: DW];
  endfunction

  a_r1_stage_only: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && ldac_n && c_ctrl == 2'b01 |=> $stable(dac_codes));

  a_r2_stage_and_out: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && c_ctrl == 2'b11 |=> pick(dac_codes, $past(c_addr)) == $past(c_data));

  a_r4_broadcast: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && c_ctrl == 2'b00 && c_addr[1:0] == 2'b01 |=> dac_codes == {NCH{$past(c_data)}});

  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && ldac_n && c_ctrl == 2'b00 && c_addr[1:0] == 2'b00
      |=> $stable(dac_codes) && $stable(dout_on_fall));

  a_r6_fall_mode: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && c_ctrl == 2'b00 && c_addr[1:0] == 2'b10 |=> dout_on_fall);

  a_r6_rise_mode: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && c_ctrl == 2'b00 && c_addr[1:0] == 2'b11 |=> !dout_on_fall);

  a_r7_transparent: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    live && !ldac_n && c_ctrl == 2'b01 |=> pick(dac_codes, $past(c_addr)) == $past(c_data));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_codes == '0);

  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |-> dac_codes == '0 && !dout_on_fall);
endmodule

bind qdac_regbank qdac_regbank_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
  .cmd_valid(cmd_valid), .cmd_word(cmd_word), .dac_codes(dac_codes),
  .dout_on_fall(dout_on_fall), .por_rel_n(por_rel_n), .clr_rel_n(clr_rel_n)
);

// File: tb/qdac_regbank_tb_top.sv
module qdac_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_n;
  logic        ldac_n;
  logic        cmd_valid;
  logic [11:0] cmd_word;
  logic [31:0] dac_codes;
  logic        dout_on_fall;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  qdac_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dac_codes(dac_codes), .dout_on_fall(dout_on_fall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] a, input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {a, c, d};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr_n = 1'b1; ldac_n = 1'b1; cmd_valid = 1'b0; cmd_word = '0;
    repeat (3) @(negedge clk);
    chk("R9 codes in reset", dac_codes, 32'h0);
    chk("R9 edge flag in reset", {31'b0, dout_on_fall}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_stage();
    issue(2'd0, 2'b01, 8'h12);
    issue(2'd1, 2'b01, 8'h34);
    issue(2'd2, 2'b01, 8'h56);
    issue(2'd3, 2'b01, 8'h78);
    chk("R1 outputs unchanged by staging", dac_codes, 32'h0);
    issue(2'd0, 2'b10, 8'hC3);
    chk("R3 transfer staged codes", dac_codes, 32'h78563412);
  endtask

  task automatic t_both();
    issue(2'd2, 2'b11, 8'hA5);
    chk("R2 stage and output", dac_codes, 32'h78A53412);
    issue(2'd1, 2'b10, 8'h00);
    chk("R2 staging also written", dac_codes, 32'h78A53412);
  endtask

  task automatic t_bcast();
    issue(2'd1, 2'b00, 8'h3C);
    chk("R4 broadcast", dac_codes, 32'h3C3C3C3C);
    issue(2'd0, 2'b10, 8'h00);
    chk("R4 staging untouched", dac_codes, 32'h78A53412);
  endtask

  task automatic t_idle();
    issue(2'd0, 2'b00, 8'hFF);
    chk("R5 nop codes", dac_codes, 32'h78A53412);
    chk("R5 nop flag", {31'b0, dout_on_fall}, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = {2'd0, 2'b11, 8'hEE};
    @(negedge clk);
    chk("R11 strobe low ignored", dac_codes, 32'h78A53412);
    issue(2'd0, 2'b10, 8'h00);
    chk("R11 R5 staging unchanged", dac_codes, 32'h78A53412);
  endtask

  task automatic t_mode();
    issue(2'd0, 2'b01, 8'h99);
    issue(2'd2, 2'b00, 8'h00);
    chk("R6 fall flag", {31'b0, dout_on_fall}, 32'h1);
    chk("R6 fall transfers", dac_codes, 32'h78A53499);
    issue(2'd1, 2'b01, 8'h11);
    issue(2'd3, 2'b00, 8'h00);
    chk("R6 rise flag", {31'b0, dout_on_fall}, 32'h0);
    chk("R6 rise transfers", dac_codes, 32'h78A51199);
    issue(2'd2, 2'b00, 8'h00);
  endtask

  task automatic t_ldac();
    @(negedge clk);
    ldac_n = 1'b0;
    issue(2'd2, 2'b01, 8'h5A);
    chk("R7 transparent load", dac_codes, 32'h785A1199);
    ldac_n = 1'b1;
    issue(2'd2, 2'b01, 8'h22);
    chk("R1 opaque again", dac_codes, 32'h785A1199);
  endtask

  task automatic t_clear();
    @(negedge clk);
    ldac_n    = 1'b0;
    clr_n     = 1'b0;
    cmd_valid = 1'b1;
    cmd_word  = {2'd0, 2'b11, 8'hEE};
    #2;
    chk("R8 async clear", dac_codes, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 command blocked by clear", dac_codes, 32'h0);
    chk("R8 flag kept", {31'b0, dout_on_fall}, 32'h1);
    clr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 transparent after clear", dac_codes, 32'h0);
    ldac_n = 1'b1;
    issue(2'd0, 2'b10, 8'h00);
    chk("R8 staging cleared", dac_codes, 32'h0);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R9 reset clears flag", {31'b0, dout_on_fall}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_stage();
    t_both();
    t_bcast();
    t_idle();
    t_mode();
    t_ldac();
    t_clear();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule